// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Bank

This block is a byte-wide register bank for a real-time clock. Software reaches it through two ports: a write to the index port picks a register, and later reads and writes on the data port act on that picked register. Indices 0x0 to 0x9 hold time and calendar bytes, kept as plain binary bytes. Indices 0xA to 0xD are status and control registers. The block does not advance the calendar and does not match alarms. A load strobe fills the calendar bytes from a set of starting values.

The block also holds a periodic interrupt timer. It counts the cycles of a fixed tick enable and gives a one-cycle interrupt pulse each time a programmed number of ticks has passed. A control bit starts and stops the timer. The block accepts only a narrow set of status and control values. An out-of-range index, or any write the block does not support, sets a sticky error output.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, `rdata`, `rd_valid`, `irq` and `err` are 0, the selected index is 0x0, all ten calendar bytes are 0x00, control register A holds 0x26 with bit 7 clear, and control register B holds 0x46.
- R2: A write of 0x0 to 0xD on the index port selects that register. A larger value is not latched: the previous index stays in force and `err` is set.
- R3: At indices 0x0 to 0x9, a data write stores the byte unchanged and a later read returns it.
- R4: Each read of register A (index 0xA) inverts bit 7, the update-in-progress bit, and returns the inverted value. After reset the reads give 0xA6, 0x26, 0xA6 and so on.
- R5: A write of exactly 0x26 to register A is accepted and replaces its contents, which also clears bit 7. Any other value leaves the register unchanged and sets `err`.
- R6: A write to register B (index 0xB) is accepted only if the value, with bit 6 (periodic enable) and bit 3 (square-wave enable) masked off, equals 0x06 (bit 2 binary, bit 1 24-hour). A rejected write leaves B unchanged and sets `err`.
- R7: Registers C and D (0xC and 0xD) always read 0x00. A write to either one sets `err`.
- R8: On the cycle after `init_load`, calendar byte 0 holds the seconds, byte 2 the minutes, byte 4 the hours, byte 6 the zero-based weekday plus one, byte 7 the day of the month, byte 8 the zero-based month plus one, and byte 9 the year.
- R9: While the timer runs, `irq` is high for exactly one cycle after every TICK_PERIOD-th `tick_en` cycle, counted from the cycle the timer started. The count reloads by itself. TICK_PERIOD is at least 2.
- R10: An accepted write to register B with bit 6 clear stops the timer. If this write falls in the same cycle as an expiry, no pulse is given. An accepted write with bit 6 set starts an idle timer from a count of zero, and has no effect on a timer that is already running.
- R11: Once `err` is set it stays high until reset.
- R12: A `data_rd` strobe gives the selected register's value on `rdata`, with `rd_valid` high, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One tick of the periodic timer's time base |
| idx_wr | input | 1 | Write `wdata` to the index port |
| data_wr | input | 1 | Write `wdata` to the selected register |
| data_rd | input | 1 | Read the selected register |
| wdata | input | 8 | Write byte for both ports |
| init_load | input | 1 | Load the calendar bytes from the init inputs |
| init_sec | input | 8 | Starting seconds |
| init_min | input | 8 | Starting minutes |
| init_hour | input | 8 | Starting hours |
| init_wday | input | 8 | Starting weekday, zero-based |
| init_mday | input | 8 | Starting day of the month |
| init_mon | input | 8 | Starting month, zero-based |
| init_year | input | 8 | Starting year |
| rdata | output | 8 | Read byte |
| rd_valid | output | 1 | `rdata` holds a read result |
| irq | output | 1 | Periodic interrupt pulse |
| err | output | 1 | Sticky flag for unsupported accesses |

## Verification
Two functions can fall in the same cycle: the timer's expiry and a register B write that clears the periodic enable. The bench provokes this by giving one tick fewer than the period, then driving the final tick and the stopping write together on one edge. It then judges that no pulse appears, neither in that cycle nor over two further periods of ticks. It also counts the pulses of a freshly started timer and checks where the first one lands, so that a stop which only gates the output can be told apart from one that really halts the count.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned CAL_BYTES = 10;

  localparam logic [IDX_W-1:0] IDX_A    = 4'hA;
  localparam logic [IDX_W-1:0] IDX_B    = 4'hB;
  localparam logic [IDX_W-1:0] IDX_C    = 4'hC;
  localparam logic [IDX_W-1:0] IDX_LAST = 4'hD;

  localparam logic [BYTE_W-1:0] A_BUSY   = 8'h80;
  localparam logic [BYTE_W-1:0] A_RESET  = 8'h26;
  localparam logic [BYTE_W-1:0] B_PERIOD = 8'h40;
  localparam logic [BYTE_W-1:0] B_SQW    = 8'h08;
  localparam logic [BYTE_W-1:0] B_BINARY = 8'h04;
  localparam logic [BYTE_W-1:0] B_H24    = 8'h02;
  localparam logic [BYTE_W-1:0] B_RESET  = B_PERIOD | B_BINARY | B_H24;

  typedef enum logic [IDX_W-1:0] {
    SLOT_SEC  = 4'd0,
    SLOT_MIN  = 4'd2,
    SLOT_HOUR = 4'd4,
    SLOT_WDAY = 4'd6,
    SLOT_MDAY = 4'd7,
    SLOT_MON  = 4'd8,
    SLOT_YEAR = 4'd9
  } cal_slot_e;

  function automatic logic index_ok(input logic [BYTE_W-1:0] v);
    return v <= {4'h0, IDX_LAST};
  endfunction

  function automatic logic reg_a_ok(input logic [BYTE_W-1:0] v);
    return v == A_RESET;
  endfunction

  function automatic logic reg_b_ok(input logic [BYTE_W-1:0] v);
    return (v & ~(B_PERIOD | B_SQW)) == (B_BINARY | B_H24);
  endfunction

  function automatic logic [BYTE_W-1:0] one_based(input logic [BYTE_W-1:0] v);
    return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch
  import rtc_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              bad_index
);
  assign bad_index = idx_wr && !index_ok(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_wr && index_ok(wdata))
      idx_q <= wdata[IDX_W-1:0];
  end
endmodule

// File: rtl/rtc_cal_array.sv
module rtc_cal_array
  import rtc_regbank_pkg::*;
#(
  parameter int unsigned BYTES = CAL_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              init_load,
  input  logic [BYTE_W-1:0] init_sec,
  input  logic [BYTE_W-1:0] init_min,
  input  logic [BYTE_W-1:0] init_hour,
  input  logic [BYTE_W-1:0] init_wday,
  input  logic [BYTE_W-1:0] init_mday,
  input  logic [BYTE_W-1:0] init_mon,
  input  logic [BYTE_W-1:0] init_year,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] cells [BYTES];
  logic [BYTE_W-1:0] seed  [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

    always_comb begin
      case (SLOT)
        SLOT_SEC:  seed[g] = init_sec;
        SLOT_MIN:  seed[g] = init_min;
        SLOT_HOUR: seed[g] = init_hour;
        SLOT_WDAY: seed[g] = one_based(init_wday);
        SLOT_MDAY: seed[g] = init_mday;
        SLOT_MON:  seed[g] = one_based(init_mon);
        SLOT_YEAR: seed[g] = init_year;
        default:   seed[g] = cells[g];
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= '0;
      else if (init_load)
        cells[g] <= seed[g];
      else if (wr_en && idx == SLOT)
        cells[g] <= wdata;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < BYTES; i++)
      if (idx == IDX_W'(i)) rd_byte = cells[i];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_a,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] reg_a_q,
  output logic [BYTE_W-1:0] reg_b_q,
  output logic              bad_write,
  output logic              run_req,
  output logic              stop_req
);
  logic a_take, b_take;

  assign a_take    = wr_a && reg_a_ok(wdata);
  assign b_take    = wr_b && reg_b_ok(wdata);
  assign bad_write = (wr_a && !a_take) || (wr_b && !b_take);
  assign run_req   = b_take && ((wdata & B_PERIOD) != '0);
  assign stop_req  = b_take && ((wdata & B_PERIOD) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a_q <= A_RESET;
      reg_b_q <= B_RESET;
    end else begin
      if (a_take)
        reg_a_q <= wdata;
      else if (rd_a && !wr_a)
        reg_a_q <= reg_a_q ^ A_BUSY;
      if (b_take)
        reg_b_q <= wdata;
    end
  end
endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer #(
  parameter int unsigned TICK_PERIOD = 8,
  localparam int unsigned CNT_W = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run_req,
  input  logic stop_req,
  output logic running,
  output logic expire,
  output logic irq
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_PERIOD - 1);
  logic [CNT_W-1:0] cnt_q;

  assign expire = running && tick_en && !stop_req && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b1;
      cnt_q   <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= expire;
      if (stop_req) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else if (run_req && !running) begin
        running <= 1'b1;
        cnt_q   <= '0;
      end else if (running && tick_en) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int unsigned TICK_PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  input  logic       init_load,
  input  logic [7:0] init_sec,
  input  logic [7:0] init_min,
  input  logic [7:0] init_hour,
  input  logic [7:0] init_wday,
  input  logic [7:0] init_mday,
  input  logic [7:0] init_mon,
  input  logic [7:0] init_year,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic       irq,
  output logic       err
);
  logic [IDX_W-1:0]  idx_q;
  logic              bad_index, bad_ctrl, bad_cd, err_set;
  logic              sel_cal, sel_a, sel_b, sel_cd;
  logic [BYTE_W-1:0] cal_byte, reg_a_q, reg_b_q, rd_next;
  logic              run_req, stop_req, running, expire;

  assign sel_cal = idx_q < IDX_W'(CAL_BYTES);
  assign sel_a   = idx_q == IDX_A;
  assign sel_b   = idx_q == IDX_B;
  assign sel_cd  = idx_q >= IDX_C;

  rtc_index_latch u_index (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(wdata),
    .idx_q(idx_q), .bad_index(bad_index)
  );

  rtc_cal_array #(.BYTES(CAL_BYTES)) u_cal (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr && sel_cal), .idx(idx_q),
    .wdata(wdata), .init_load(init_load),
    .init_sec(init_sec), .init_min(init_min), .init_hour(init_hour),
    .init_wday(init_wday), .init_mday(init_mday), .init_mon(init_mon),
    .init_year(init_year), .rd_byte(cal_byte)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_a(data_rd && sel_a),
    .wr_a(data_wr && sel_a), .wr_b(data_wr && sel_b), .wdata(wdata),
    .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .bad_write(bad_ctrl),
    .run_req(run_req), .stop_req(stop_req)
  );

  rtc_period_timer #(.TICK_PERIOD(TICK_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_req(run_req),
    .stop_req(stop_req), .running(running), .expire(expire), .irq(irq)
  );

  assign bad_cd  = data_wr && sel_cd;
  assign err_set = bad_index || bad_ctrl || bad_cd;

  always_comb begin
    if (sel_cal)    rd_next = cal_byte;
    else if (sel_a) rd_next = reg_a_q ^ A_BUSY;
    else if (sel_b) rd_next = reg_b_q;
    else            rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= data_rd;
      if (data_rd) rdata <= rd_next;
      if (err_set) err <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_regbank_checker.sv
module rtc_regbank_checker
  import rtc_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              idx_wr,
  input logic              data_wr,
  input logic              data_rd,
  input logic [BYTE_W-1:0] wdata,
  input logic [IDX_W-1:0]  idx_q,
  input logic [BYTE_W-1:0] reg_a_q,
  input logic [BYTE_W-1:0] reg_b_q,
  input logic              running,
  input logic [BYTE_W-1:0] rdata,
  input logic              rd_valid,
  input logic              irq,
  input logic              err
);
  p_index_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST);

  p_bad_index_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr && !index_ok(wdata) |=> $stable(idx_q) && err);

  p_busy_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !data_wr && idx_q == IDX_A |=> reg_a_q[7] != $past(reg_a_q[7]));

  p_bad_b_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && idx_q == IDX_B && !reg_b_ok(wdata) |=> $stable(reg_b_q) && err);

  p_cd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && idx_q >= IDX_C |=> rdata == '0);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !irq);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_read_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> rd_valid);
endmodule

bind rtc_regbank rtc_regbank_checker u_checker (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
  .data_rd(data_rd), .wdata(wdata), .idx_q(idx_q), .reg_a_q(reg_a_q),
  .reg_b_q(reg_b_q), .running(running), .rdata(rdata),
  .rd_valid(rd_valid), .irq(irq), .err(err)
);

// File: tb/test_rtc_regbank.sv
module test_rtc_regbank;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic       init_load = 1'b0;
  logic [7:0] init_sec = '0, init_min = '0, init_hour = '0, init_wday = '0;
  logic [7:0] init_mday = '0, init_mon = '0, init_year = '0;
  logic [7:0] rdata;
  logic       rd_valid, irq, err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  rtc_regbank #(.TICK_PERIOD(P)) i_rtc_regbank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idx_wr(idx_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata),
    .init_load(init_load), .init_sec(init_sec), .init_min(init_min),
    .init_hour(init_hour), .init_wday(init_wday), .init_mday(init_mday),
    .init_mon(init_mon), .init_year(init_year), .rdata(rdata),
    .rd_valid(rd_valid), .irq(irq), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: actual unexpected read 0x%0h expected none", rdata);
      end else begin
        chk(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic get(input logic [7:0] exp, input string req);
    @(negedge clk); data_rd = 1'b1; exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic ticks(input int n, output int pulses, output int first);
    pulses = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      if (irq) begin
        pulses++;
        if (first < 0) first = i;
      end
    end
    tick_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1..: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int pulses, first;
    do_reset();
    @(negedge clk);
    chk("R1 rdata", rdata, 0); chk("R1 irq", irq, 0);
    chk("R1 err", err, 0);     chk("R1 rd_valid", rd_valid, 0);
    get(8'h00, "R1 byte0");

    set_idx(8'h03); put(8'h5A); get(8'h5A, "R3 byte3");
    set_idx(8'h09); put(8'hC3); get(8'hC3, "R3 byte9");
    set_idx(8'h03); get(8'h5A, "R3 byte3 again");

    set_idx(8'h0A);
    get(8'hA6, "R4 first"); get(8'h26, "R4 second"); get(8'hA6, "R4 third");
    put(8'h26); get(8'hA6, "R5 accepted write");
    chk("R5 err", err, 0);

    set_idx(8'h0B); get(8'h46, "R1 reg B");
    put(8'h0E); get(8'h0E, "R6 accepted 0x0E");
    put(8'h46); get(8'h46, "R6 accepted 0x46");
    chk("R6 err", err, 0);

    set_idx(8'h0C); get(8'h00, "R7 C");
    set_idx(8'h0D); get(8'h00, "R7 D");
    chk("R7 err", err, 0);

    @(negedge clk);
    init_sec = 8'd5; init_min = 8'd6; init_hour = 8'd7; init_wday = 8'd3;
    init_mday = 8'd9; init_mon = 8'd11; init_year = 8'd99; init_load = 1'b1;
    @(negedge clk); init_load = 1'b0;
    set_idx(8'h00); get(8'd5, "R8 sec");
    set_idx(8'h02); get(8'd6, "R8 min");
    set_idx(8'h04); get(8'd7, "R8 hour");
    set_idx(8'h06); get(8'd4, "R8 wday");
    set_idx(8'h07); get(8'd9, "R8 mday");
    set_idx(8'h08); get(8'd12, "R8 mon");
    set_idx(8'h09); get(8'd99, "R8 year");

    // R9: fresh start, three periods
    set_idx(8'h0B); put(8'h06); put(8'h46);
    ticks(3 * P, pulses, first);
    chk("R9 pulse count", pulses, 3); chk("R9 first pulse", first, P);

    // R10: stopped timer stays quiet
    put(8'h06);
    ticks(3 * P, pulses, first);
    chk("R10 stopped", pulses, 0);

    // R10: stop write in the same cycle as the expiring tick
    put(8'h46);
    ticks(P - 1, pulses, first);
    chk("R10 pre-expiry", pulses, 0);
    tick_en = 1'b1; data_wr = 1'b1; wdata = 8'h06;
    @(negedge clk);
    tick_en = 1'b0; data_wr = 1'b0;
    chk("R10 same-cycle stop", irq, 0);
    ticks(2 * P, pulses, first);
    chk("R10 after same-cycle stop", pulses, 0);
    put(8'h46);
    ticks(P, pulses, first);
    chk("R10 restart", pulses, 1);

    // R2 / R11
    set_idx(8'h07); set_idx(8'h0E);
    @(negedge clk); chk("R2 err", err, 1);
    get(8'd9, "R2 index kept");
    set_idx(8'h03); put(8'h11);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R11 sticky", err, 1);
    do_reset(); @(negedge clk); chk("R11 cleared by reset", err, 0);

    set_idx(8'h0A); put(8'h20);
    @(negedge clk); chk("R5 bad write err", err, 1);
    get(8'hA6, "R5 unchanged");
    do_reset();

    set_idx(8'h0B); put(8'h47);
    @(negedge clk); chk("R6 bad write err", err, 1);
    get(8'h46, "R6 unchanged");
    do_reset();

    set_idx(8'h0C); put(8'h00);
    @(negedge clk); chk("R7 write err", err, 1);
    get(8'h00, "R7 C after write");

    @(negedge clk); @(negedge clk);
    chk("R12 queue drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule